// File: doc/BRIEF.md
# Block-Transfer Bus Slot Sequencer

This block lays out, cycle by cycle, the bus slots a block-transfer engine uses. The engine has three source fetch channels (A, B, C) and one destination write channel (D). A 4-bit channel-enable code picks which channels take part. After a start pulse with a word count, the block presents one slot per cycle. Each slot is a fetch for A, B or C, a destination write, or an idle slot, and it comes with the word index it serves. When the last slot has been taken, the block raises a one-cycle done flag.

The block only schedules slots. It does not move data, evaluate logic functions, shift, fill or form addresses. It assumes area fill is off. Competition with other bus masters shows up only through the grant input: while grant is low, the sequence stays on its current slot. Because of pipelining, a destination write trails the source fetches by one word. Each channel combination has its own idle padding, and most combinations end with a trailing write that flushes the pipeline.

Top module: `blit_dma_sequencer`

## Requirements
- R1: Bit 3 of `chan_en_i` enables A, bit 2 enables B, bit 1 enables C and bit 0 enables D. The code is captured at start. A code of 0 issues no slot, and done rises in the cycle after the start pulse.
- R2: In the group of slots for one word, the enabled fetches come first in the order A, B, C. The destination slot follows them when D is enabled, and padding idles come last.
- R3: When D is enabled with at least one source, the destination slot in the group of word n writes word n-1. In the group of word 0 that slot is idle.
- R4: After the group of the last word N-1, a trailing write of word N-1 follows. For code 0xF, 0x7, 0x5 and 0x3 this is a single D slot. For 0xD, 0xB and 0x9 it is an idle slot and then the D slot. Code 0x1 (D alone) has no lag and no trailing write: each group writes its own word.
- R5: Every group, including the last, ends with padding idles. There are two for code 0x4, none for 0xF, 0xE, 0xD, 0xB, 0xA and 0x9, and one for every other nonzero code.
- R6: `slot_o` encodes idle=0, A=1, B=2, C=3, D=4. A fetch carries the index of its group's word, and an idle slot carries index 0.
- R7: A slot is taken only in a cycle where `grant_i` is high. While grant is low, `slot_o` and `idx_o` hold and the sequence does not advance.
- R8: `done_o` is high for exactly one cycle, in the cycle after the final slot is taken. Outside a running sequence, `slot_o` and `idx_o` read 0.
- R9: A start pulse while a sequence runs, or while done is high, is ignored. The running stream is unchanged and no second transfer follows.
- R10: A start pulse with a word count of 0 or above `MAX_WORDS` is ignored: no slot is issued and done does not rise.
- R11: Reset, whether at power-up or during a sequence, returns the block to the idle state, with slot 0, index 0 and done low.
- R12: The first slot of an accepted transfer appears in the cycle after the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| chan_en_i | input | 4 | Channel-enable code (A, B, C, D from bit 3 down) |
| words_i | input | CNT_W | Word count, 1 to MAX_WORDS |
| grant_i | input | 1 | Bus grant; low stalls the sequence |
| slot_o | output | 3 | Current slot code |
| idx_o | output | IDX_W | Word index of the current slot |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Some properties are checked on every cycle, whatever the stimulus: idle slots carry index zero, the outputs hold while grant is low, done lasts a single cycle and never comes with a live slot, the outputs are quiet outside a sequence, and an accepted start launches a sequence on the next edge. Other behaviour is only visible in the full slot stream for a given code and length: the per-code fetch order, the padding counts, the one-word destination lag, the trailing flush write, and the rejection of a second start or a bad count. The bench scenarios cover these. Its reference stream is rebuilt from the ordering and padding rules for all sixteen codes and several word counts and grant patterns.

// File: rtl/blit_seq_pkg.sv
package blit_seq_pkg;

   typedef enum logic [2:0] {
      SLOT_IDLE = 3'd0,
      SLOT_A    = 3'd1,
      SLOT_B    = 3'd2,
      SLOT_C    = 3'd3,
      SLOT_D    = 3'd4
   } slot_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } seq_st_e;

   // three sources plus one destination slot fill at most four positions
   localparam int GRP_MAX = 4;
   localparam int POS_W   = 2;
   localparam int GLEN_W  = 3;

   // idle slots appended to every word group
   function automatic logic [1:0] pad_slots(input logic [3:0] code);
      case (code)
         4'h4:                                     return 2'd2;
         4'hF, 4'hE, 4'hD, 4'hB, 4'hA, 4'h9, 4'h0: return 2'd0;
         default:                                  return 2'd1;
      endcase
   endfunction

   // trailing flush write is preceded by an idle slot
   function automatic logic flush_lead(input logic [3:0] code);
      return (code == 4'hD) || (code == 4'hB) || (code == 4'h9);
   endfunction

endpackage

// File: rtl/slot_pattern_dec.sv
module slot_pattern_dec
   import blit_seq_pkg::*;
(
   input  logic [3:0]        code_i,
   output slot_e             tmpl_o [GRP_MAX],
   output logic [GLEN_W-1:0] glen_o,
   output logic [1:0]        tlen_o,
   output logic              lag_o,
   output logic              tlead_o
);

   slot_e             fill [GRP_MAX];
   logic [GLEN_W-1:0] nfill;

   // pack the enabled channels into consecutive positions
   always_comb begin
      for (int i = 0; i < GRP_MAX; i++) fill[i] = SLOT_IDLE;
      nfill = '0;
      if (code_i[3]) begin
         fill[nfill[POS_W-1:0]] = SLOT_A;
         nfill = nfill + 3'd1;
      end
      if (code_i[2]) begin
         fill[nfill[POS_W-1:0]] = SLOT_B;
         nfill = nfill + 3'd1;
      end
      if (code_i[1]) begin
         fill[nfill[POS_W-1:0]] = SLOT_C;
         nfill = nfill + 3'd1;
      end
      if (code_i[0]) begin
         fill[nfill[POS_W-1:0]] = SLOT_D;
         nfill = nfill + 3'd1;
      end
   end

   // positions past the channel slots become padding idles
   for (genvar g = 0; g < GRP_MAX; g++) begin : g_pos
      assign tmpl_o[g] = (GLEN_W'(g) < nfill) ? fill[g] : SLOT_IDLE;
   end

   assign glen_o  = nfill + {1'b0, pad_slots(code_i)};
   assign lag_o   = code_i[0] & (|code_i[3:1]);
   assign tlead_o = flush_lead(code_i);
   assign tlen_o  = lag_o ? (tlead_o ? 2'd2 : 2'd1) : 2'd0;

endmodule

// File: rtl/slot_walker.sv
module slot_walker
   import blit_seq_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [GLEN_W-1:0] glen_i,
   input  logic [1:0]        tlen_i,
   input  logic [IDX_W-1:0]  last_i,
   output logic [POS_W-1:0]  pos_o,
   output logic [IDX_W-1:0]  word_o,
   output logic              tail_o,
   output logic              final_o
);

   logic [POS_W-1:0] pos_q;
   logic [IDX_W-1:0] word_q;
   logic             tail_q;
   logic             grp_end, tail_end, last_word;

   assign grp_end   = ({1'b0, pos_q} == (glen_i - 3'd1));
   assign tail_end  = (pos_q == (tlen_i - 2'd1));
   assign last_word = (word_q == last_i);
   assign final_o   = tail_q ? tail_end
                             : (grp_end && last_word && (tlen_i == 2'd0));

   always_ff @(posedge clk_i) begin
      if (!rst_ni || load_i) begin
         pos_q  <= '0;
         word_q <= '0;
         tail_q <= 1'b0;
      end else if (step_i) begin
         if (tail_q) begin
            pos_q <= pos_q + 2'd1;
         end else if (grp_end) begin
            pos_q <= '0;
            if (last_word) tail_q <= 1'b1;
            else           word_q <= word_q + 1'b1;
         end else begin
            pos_q <= pos_q + 2'd1;
         end
      end
   end

   assign pos_o  = pos_q;
   assign word_o = word_q;
   assign tail_o = tail_q;

endmodule

// File: rtl/slot_emit.sv
module slot_emit
   import blit_seq_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic             run_i,
   input  slot_e            tmpl_i [GRP_MAX],
   input  logic [POS_W-1:0] pos_i,
   input  logic [IDX_W-1:0] word_i,
   input  logic [IDX_W-1:0] last_i,
   input  logic             tail_i,
   input  logic             tlead_i,
   input  logic             lag_i,
   output slot_e            slot_o,
   output logic [IDX_W-1:0] idx_o
);

   slot_e kind;

   assign kind = tmpl_i[pos_i];

   always_comb begin
      slot_o = SLOT_IDLE;
      idx_o  = '0;
      if (run_i) begin
         if (tail_i) begin
            if (!(tlead_i && (pos_i == '0))) begin
               slot_o = SLOT_D;
               idx_o  = last_i;
            end
         end else begin
            case (kind)
               SLOT_D: begin
                  if (!lag_i) begin
                     slot_o = SLOT_D;
                     idx_o  = word_i;
                  end else if (word_i != '0) begin
                     slot_o = SLOT_D;
                     idx_o  = word_i - 1'b1;
                  end
               end
               SLOT_IDLE: ;
               default: begin
                  slot_o = kind;
                  idx_o  = word_i;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/blit_dma_sequencer.sv
module blit_dma_sequencer
   import blit_seq_pkg::*;
#(
   parameter  int MAX_WORDS = 1024,
   localparam int CNT_W     = $clog2(MAX_WORDS + 1),
   localparam int IDX_W     = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic [3:0]       chan_en_i,
   input  logic [CNT_W-1:0] words_i,
   input  logic             grant_i,
   output logic [2:0]       slot_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o
);

   if (MAX_WORDS < 1) begin : g_bad_min
      $error("blit_dma_sequencer: MAX_WORDS must be at least 1");
   end
   if (MAX_WORDS > (1 << 20)) begin : g_bad_max
      $error("blit_dma_sequencer: MAX_WORDS above supported range");
   end

   seq_st_e           st_q, st_d;
   logic [3:0]        code_q;
   logic [IDX_W-1:0]  last_q;
   logic              words_ok, accept, run, step;

   slot_e             tmpl [GRP_MAX];
   logic [GLEN_W-1:0] glen;
   logic [1:0]        tlen;
   logic              lag, tlead;
   logic [POS_W-1:0]  pos;
   logic [IDX_W-1:0]  word;
   logic              tail, last_slot;
   slot_e             slot;

   assign words_ok = (words_i != '0) && (words_i <= CNT_W'(MAX_WORDS));
   assign accept   = (st_q == ST_IDLE) && start_i && words_ok;
   assign run      = (st_q == ST_RUN);
   assign step     = run && grant_i;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (accept) st_d = (chan_en_i == 4'h0) ? ST_DONE : ST_RUN;
         ST_RUN:  if (step && last_slot) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         code_q <= '0;
         last_q <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            code_q <= chan_en_i;
            last_q <= IDX_W'(words_i - 1'b1);
         end
      end
   end

   slot_pattern_dec u_dec (
      .code_i  (code_q),
      .tmpl_o  (tmpl),
      .glen_o  (glen),
      .tlen_o  (tlen),
      .lag_o   (lag),
      .tlead_o (tlead)
   );

   slot_walker #(.IDX_W(IDX_W)) u_walk (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (accept),
      .step_i  (step),
      .glen_i  (glen),
      .tlen_i  (tlen),
      .last_i  (last_q),
      .pos_o   (pos),
      .word_o  (word),
      .tail_o  (tail),
      .final_o (last_slot)
   );

   slot_emit #(.IDX_W(IDX_W)) u_emit (
      .run_i   (run),
      .tmpl_i  (tmpl),
      .pos_i   (pos),
      .word_i  (word),
      .last_i  (last_q),
      .tail_i  (tail),
      .tlead_i (tlead),
      .lag_i   (lag),
      .slot_o  (slot),
      .idx_o   (idx_o)
   );

   assign slot_o = slot;
   assign done_o = (st_q == ST_DONE);

endmodule

// File: rtl/blit_seq_chk.sv
module blit_seq_chk #(
   parameter int MAX_WORDS = 1024,
   parameter int CNT_W     = 11,
   parameter int IDX_W     = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             start_i,
   input logic [CNT_W-1:0] words_i,
   input logic             grant_i,
   input logic             run_i,
   input logic [2:0]       slot_i,
   input logic [IDX_W-1:0] idx_i,
   input logic             done_i
);

   // R6
   idle_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (slot_i == 3'd0) |-> (idx_i == '0));

   // R6
   slot_code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_i <= 3'd4);

   // R7
   grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && !grant_i) |=> ($stable(slot_i) && $stable(idx_i)));

   // R8
   done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |=> !done_i);

   // R8
   done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i |-> (slot_i == 3'd0));

   // R8
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |-> ((slot_i == 3'd0) && (idx_i == '0)));

   // R12
   start_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !run_i && !done_i && (words_i != '0) &&
       (words_i <= CNT_W'(MAX_WORDS))) |=> (run_i || done_i));

endmodule

bind blit_dma_sequencer blit_seq_chk #(
   .MAX_WORDS (MAX_WORDS),
   .CNT_W     (CNT_W),
   .IDX_W     (IDX_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .start_i (start_i),
   .words_i (words_i),
   .grant_i (grant_i),
   .run_i   (run),
   .slot_i  (slot_o),
   .idx_i   (idx_o),
   .done_i  (done_o)
);

// File: tb/test_blit_dma_sequencer.sv
`timescale 1ns/1ps
module test_blit_dma_sequencer;

   localparam int MAXW  = 1024;
   localparam int CNT_W = 11;
   localparam int IDX_W = 10;
   localparam int NV    = 24;

   // {code[32:29], words[28:18], grant mode[17:16], expected slot count[15:0]}
   localparam logic [32:0] VEC [NV] = '{
      {4'hF, 11'd3, 2'd0, 16'd13}, {4'hE, 11'd3, 2'd0, 16'd9},
      {4'hD, 11'd3, 2'd0, 16'd11}, {4'hC, 11'd3, 2'd0, 16'd9},
      {4'hB, 11'd3, 2'd0, 16'd11}, {4'hA, 11'd3, 2'd0, 16'd6},
      {4'h9, 11'd3, 2'd0, 16'd8},  {4'h8, 11'd3, 2'd0, 16'd6},
      {4'h7, 11'd3, 2'd0, 16'd13}, {4'h6, 11'd3, 2'd0, 16'd9},
      {4'h5, 11'd3, 2'd0, 16'd10}, {4'h4, 11'd3, 2'd0, 16'd9},
      {4'h3, 11'd3, 2'd0, 16'd10}, {4'h2, 11'd3, 2'd0, 16'd6},
      {4'h1, 11'd3, 2'd0, 16'd6},  {4'h0, 11'd3, 2'd0, 16'd0},
      {4'hF, 11'd1, 2'd1, 16'd5},  {4'h9, 11'd1, 2'd2, 16'd4},
      {4'h4, 11'd2, 2'd1, 16'd6},  {4'h1, 11'd1, 2'd0, 16'd2},
      {4'h7, 11'd5, 2'd2, 16'd21}, {4'hD, 11'd4, 2'd1, 16'd14},
      {4'hB, 11'd2, 2'd2, 16'd8},  {4'hE, 11'd1024, 2'd0, 16'd3072}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic             grant = 1'b0;
   logic [3:0]       chan = '0;
   logic [CNT_W-1:0] words = '0;
   logic [2:0]       slot;
   logic [IDX_W-1:0] idx;
   logic             done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [2:0] exp_s[$];
   int         exp_i[$];

   always #2 clk = ~clk;

   blit_dma_sequencer #(.MAX_WORDS(MAXW)) i_blit_dma_sequencer (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .start_i   (start),
      .chan_en_i (chan),
      .words_i   (words),
      .grant_i   (grant),
      .slot_o    (slot),
      .idx_o     (idx),
      .done_o    (done)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL R8 watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // R5 padding count per code
   function automatic int pad_of(input logic [3:0] c);
      case (c)
         4'h4: return 2;
         4'hF, 4'hE, 4'hD, 4'hB, 4'hA, 4'h9, 4'h0: return 0;
         default: return 1;
      endcase
   endfunction

   // reference stream from R2..R6
   function automatic void build(input logic [3:0] c, input int n);
      bit has_src = (c[3:1] != 3'b000);
      exp_s.delete();
      exp_i.delete();
      for (int w = 0; w < n; w++) begin
         if (c[3]) begin exp_s.push_back(3'd1); exp_i.push_back(w); end
         if (c[2]) begin exp_s.push_back(3'd2); exp_i.push_back(w); end
         if (c[1]) begin exp_s.push_back(3'd3); exp_i.push_back(w); end
         if (c[0]) begin
            if (!has_src)    begin exp_s.push_back(3'd4); exp_i.push_back(w); end
            else if (w == 0) begin exp_s.push_back(3'd0); exp_i.push_back(0); end
            else             begin exp_s.push_back(3'd4); exp_i.push_back(w - 1); end
         end
         for (int p = 0; p < pad_of(c); p++) begin
            exp_s.push_back(3'd0); exp_i.push_back(0);
         end
      end
      if (c[0] && has_src) begin
         if (c == 4'hD || c == 4'hB || c == 4'h9) begin
            exp_s.push_back(3'd0); exp_i.push_back(0);
         end
         exp_s.push_back(3'd4); exp_i.push_back(n - 1);
      end
   endfunction

   task automatic run_xfer(input logic [3:0] c, input int n, input int gm,
                           input int exp_len, input int inject);
      int got_n = 0;
      int bad = 0;
      int hold_bad = 0;
      int loops = 0;
      logic [2:0] ps = '0;
      logic [IDX_W-1:0] pi = '0;
      bit pg = 1'b1;
      bit fin = 1'b0;
      bit g;
      build(c, n);
      @(negedge clk);
      chan = c;
      words = n[CNT_W-1:0];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!fin) begin
         if (done) begin
            fin = 1'b1;
         end else begin
            if (!pg && (slot !== ps || idx !== pi)) hold_bad++;
            case (gm)
               1:       g = (loops % 2) == 0;
               2:       g = (loops % 3) != 2;
               default: g = 1'b1;
            endcase
            grant = g;
            start = (loops == inject);
            if (loops == inject) begin
               chan  = 4'hF;
               words = 11'd2;
            end
            if (g) begin
               if (got_n < exp_s.size()) begin
                  if (slot !== exp_s[got_n] || idx !== IDX_W'(exp_i[got_n])) begin
                     if (bad == 0)
                        $display("FAIL R2 R3 R4 R5 R6 code %h slot %0d: actual %0d/%0d expected %0d/%0d",
                                 c, got_n, slot, idx, exp_s[got_n], exp_i[got_n]);
                     bad++;
                  end
               end
               got_n++;
            end
            ps = slot;
            pi = idx;
            pg = g;
            loops++;
            if (loops > 20000) fin = 1'b1;
            @(negedge clk);
         end
      end
      start = 1'b0;
      grant = 1'b0;
      // R1 R2 R3 R4 R5: stream length and content
      chk(got_n == exp_len, $sformatf("R1 R4 R5 code %h length", c), got_n, exp_len);
      chk(exp_s.size() == exp_len, $sformatf("R5 model code %h length", c), exp_s.size(), exp_len);
      chk(bad == 0, $sformatf("R2 R3 R6 code %h mismatches", c), bad, 0);
      if (gm != 0) chk(hold_bad == 0, $sformatf("R7 code %h hold breaks", c), hold_bad, 0);
      if (c == 4'h0) chk(loops == 0, "R1 code 0 done delay", loops, 0);
      // R8 single-cycle done, quiet outputs after
      @(negedge clk);
      chk(done == 1'b0, "R8 done width", done, 0);
      chk(slot == 3'd0 && idx == '0, "R8 quiet after done", slot, 0);
      if (inject >= 0) begin
         // R9: the ignored start must not launch a second transfer
         for (int k = 0; k < 6; k++) begin
            chk(done == 1'b0 && slot == 3'd0, "R9 no second transfer", slot, 0);
            @(negedge clk);
         end
      end
   endtask

   task automatic bad_count(input int n);
      @(negedge clk);
      chan = 4'hF;
      words = n[CNT_W-1:0];
      start = 1'b1;
      grant = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 6; k++) begin
         chk(done == 1'b0 && slot == 3'd0, $sformatf("R10 count %0d ignored", n), slot, 0);
         @(negedge clk);
      end
      grant = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(slot == 3'd0 && idx == '0 && done == 1'b0, "R11 reset outputs", slot, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(slot == 3'd0 && done == 1'b0, "R11 idle after reset", slot, 0);

      // R12 first slot on the cycle after start: the stream checks sample from there
      for (int v = 0; v < NV; v++) begin
         run_xfer(VEC[v][32:29], int'(VEC[v][28:18]), int'(VEC[v][17:16]),
                  int'(VEC[v][15:0]), -1);
      end

      // R9 start while busy
      run_xfer(4'h9, 3, 0, 8, 2);

      // R10 out-of-range counts
      bad_count(0);
      bad_count(MAXW + 1);

      // R11 reset during a running sequence
      @(negedge clk);
      chan = 4'hF; words = 11'd3; start = 1'b1; grant = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(slot == 3'd1, "R12 first slot A", slot, 1);
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(slot == 3'd0 && idx == '0 && done == 1'b0, "R11 reset mid-run", slot, 0);
      rst_n = 1'b1;
      grant = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0 && slot == 3'd0, "R11 stays idle after reset", slot, 0);
      run_xfer(4'h5, 1, 0, 4, -1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule